// File: doc/BRIEF.md
# PLL Reset and Lock Supervisor

This block is a synchronous controller placed next to a phase-locked loop. It keeps the loop's reset asserted until the reference clock has shown steady activity. It then holds the reset for a minimum number of system clocks and releases it. It brings the loop's asynchronous lock flag into the system clock domain and qualifies that flag with a run-length filter before it raises a clean ready status. If lock is lost, the block reissues the reset and counts the event in a saturating counter. If the reference stops, the block returns to its waiting state.

The block also drives the loop's phase-detector enable. A freeze request turns the enable off, and the loop then coasts at its last locked frequency while the system saves its state. While the detector is off, the lock flag carries no meaning. The supervisor neither acts on it nor counts it.

Top module: `pll_supervisor`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the outputs take these values on the next cycle: `pll_rst`=1, `ready`=0, `pfd_en`=1 and `loss_cnt`=0.
- R2: The reference is sampled through a SYNC_STAGES flop synchronizer, and both of its edges count as activity. Time is cut into windows of WIN_CYCLES clocks. The reference counts as good once GOOD_WINDOWS consecutive windows have each held at least one edge. Until then `pll_rst` stays at 1.
- R3: Once the reference is good, `pll_rst` stays high for exactly RST_CYCLES further clocks and is then released. The same pulse length applies after every loss of lock.
- R4: `ready` rises only after the synchronized lock flag has been high for LOCK_CYCLES consecutive clocks with `pfd_en`=1. `ready` is never 1 while `pll_rst` is 1.
- R5: While locked with `pfd_en`=1, a synchronized lock value of 0 is a loss of lock. In the next cycle `ready` falls, `pll_rst` rises, and `loss_cnt` increments by one.
- R6: `pfd_en` is the registered inverse of `freeze` and follows it one clock later.
- R7: While `pfd_en`=0, the lock flag is ignored. No reset is issued, `loss_cnt` does not change, `ready` keeps its value, and the lock run-length count is held.
- R8: A whole window with no reference edge marks the reference as bad. From any state, the next cycle then shows `pll_rst`=1 and `ready`=0, and this is not counted as a loss of lock.
- R9: `loss_cnt` is an 8-bit counter that saturates at 255.
- R10: `cnt_clr`=1 sets `loss_cnt` to 0 in the next cycle. If a loss event falls in the same cycle, the clear wins and the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Reference clock of the PLL, asynchronous, sampled as data |
| pll_lock_async | input | 1 | Lock flag from the PLL, asynchronous |
| freeze | input | 1 | Request to turn the phase detector off |
| cnt_clr | input | 1 | Clears the loss-of-lock counter |
| pll_rst | output | 1 | Reset to the PLL |
| pfd_en | output | 1 | Phase-detector enable to the PLL |
| ready | output | 1 | PLL locked and qualified |
| loss_cnt | output | 8 | Saturating loss-of-lock event count |

## Verification
A loss-of-lock increment and a counter clear can land on the same clock edge. The bench provokes this by using its reference model to predict the exact edge at which the sequencer will see the lock drop, and it raises `cnt_clr` for that one cycle only. It judges the result by requiring `loss_cnt` to read 0 afterwards. The same outputs are also compared against the model on every clock, so the reset pulse that the same edge starts is checked alongside the counter.

// File: rtl/pll_sup_pkg.sv
package pll_sup_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_REF  = 2'd0,
    ST_RESET     = 2'd1,
    ST_WAIT_LOCK = 2'd2,
    ST_LOCKED    = 2'd3
  } sup_state_t;
endpackage

// File: rtl/sync_bit.sv
module sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ref_activity_mon.sv
module ref_activity_mon #(
  parameter int SYNC_STAGES  = 2,
  parameter int WIN_CYCLES   = 16,
  parameter int GOOD_WINDOWS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_clk,
  output logic ref_ok
);
  localparam int WIN_W  = $clog2(WIN_CYCLES);
  localparam int GOOD_W = $clog2(GOOD_WINDOWS + 1);

  logic              ref_s, ref_d, tgl, seen_q, ok_q, win_end;
  logic [WIN_W-1:0]  win_q;
  logic [GOOD_W-1:0] good_q, good_d;

  sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ref_sync (
    .clk(clk), .rst(rst), .d(ref_clk), .q(ref_s)
  );

  always_ff @(posedge clk) begin
    if (rst) ref_d <= 1'b0;
    else     ref_d <= ref_s;
  end

  assign tgl     = ref_s ^ ref_d;
  assign win_end = (win_q == WIN_W'(WIN_CYCLES - 1));

  always_comb begin
    good_d = good_q;
    if (seen_q | tgl) begin
      if (good_q != GOOD_W'(GOOD_WINDOWS)) good_d = good_q + 1'b1;
    end else begin
      good_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      seen_q <= 1'b0;
      good_q <= '0;
      ok_q   <= 1'b0;
    end else if (win_end) begin
      win_q  <= '0;
      seen_q <= 1'b0;
      good_q <= good_d;
      ok_q   <= (good_d == GOOD_W'(GOOD_WINDOWS));
    end else begin
      win_q  <= win_q + 1'b1;
      seen_q <= seen_q | tgl;
    end
  end

  assign ref_ok = ok_q;

  // R2
  ref_ok_window_chk: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(ok_q))
    else $error("reference status changed inside a window");

  // R8
  ref_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (win_end && !seen_q && !tgl) |=> !ok_q)
    else $error("silent window did not clear reference status");
endmodule

// File: rtl/loss_counter.sv
module loss_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (clr)                     cnt_q <= '0;
    else if (inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX)
    else $error("loss counter wrapped");

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt_q == '0)
    else $error("clear did not zero loss counter");

  // R9
  monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cnt_q >= $past(cnt_q))
    else $error("loss counter decreased without clear");
endmodule

// File: rtl/pll_supervisor.sv
module pll_supervisor
  import pll_sup_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int WIN_CYCLES   = 16,
  parameter int GOOD_WINDOWS = 4,
  parameter int RST_CYCLES   = 8,
  parameter int LOCK_CYCLES  = 4,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_clk,
  input  logic             pll_lock_async,
  input  logic             freeze,
  input  logic             cnt_clr,
  output logic             pll_rst,
  output logic             pfd_en,
  output logic             ready,
  output logic [CNT_W-1:0] loss_cnt
);
  localparam int TMR_MAX = (RST_CYCLES > LOCK_CYCLES) ? RST_CYCLES : LOCK_CYCLES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  logic             ref_ok, lock_s, pfd_q, loss_evt;
  logic             pll_rst_q, ready_q;
  sup_state_t       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  ref_activity_mon #(
    .SYNC_STAGES(SYNC_STAGES), .WIN_CYCLES(WIN_CYCLES), .GOOD_WINDOWS(GOOD_WINDOWS)
  ) u_refmon (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .ref_ok(ref_ok)
  );

  sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock_sync (
    .clk(clk), .rst(rst), .d(pll_lock_async), .q(lock_s)
  );

  always_ff @(posedge clk) begin
    if (rst) pfd_q <= 1'b1;
    else     pfd_q <= ~freeze;
  end

  always_comb begin
    state_d  = state_q;
    tmr_d    = tmr_q;
    loss_evt = 1'b0;
    if (!ref_ok) begin
      state_d = ST_WAIT_REF;
      tmr_d   = '0;
    end else begin
      case (state_q)
        ST_WAIT_REF: begin
          state_d = ST_RESET;
          tmr_d   = '0;
        end
        ST_RESET: begin
          if (tmr_q == TMR_W'(RST_CYCLES - 1)) begin
            state_d = ST_WAIT_LOCK;
            tmr_d   = '0;
          end else begin
            tmr_d = tmr_q + 1'b1;
          end
        end
        ST_WAIT_LOCK: begin
          if (pfd_q) begin
            if (lock_s) begin
              if (tmr_q == TMR_W'(LOCK_CYCLES - 1)) begin
                state_d = ST_LOCKED;
                tmr_d   = '0;
              end else begin
                tmr_d = tmr_q + 1'b1;
              end
            end else begin
              tmr_d = '0;
            end
          end
        end
        ST_LOCKED: begin
          if (pfd_q && !lock_s) begin
            loss_evt = 1'b1;
            state_d  = ST_RESET;
            tmr_d    = '0;
          end
        end
        default: begin
          state_d = ST_WAIT_REF;
          tmr_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_WAIT_REF;
      tmr_q     <= '0;
      pll_rst_q <= 1'b1;
      ready_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      tmr_q     <= tmr_d;
      pll_rst_q <= (state_d == ST_WAIT_REF) || (state_d == ST_RESET);
      ready_q   <= (state_d == ST_LOCKED);
    end
  end

  loss_counter #(.CNT_W(CNT_W)) u_loss (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(loss_evt), .cnt(loss_cnt)
  );

  assign pll_rst = pll_rst_q;
  assign ready   = ready_q;
  assign pfd_en  = pfd_q;

  // R4
  ready_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> ($past(lock_s) && $past(pfd_q)))
    else $error("ready rose without qualified lock");

  // R5
  loss_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCKED && ref_ok && pfd_q && !lock_s) |=> (pll_rst_q && !ready_q))
    else $error("loss of lock did not reissue reset");

  // R7
  frozen_no_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (!pfd_q && ref_ok && !pll_rst_q) |=> !pll_rst_q)
    else $error("reset issued while phase detector off");

  // R7
  frozen_no_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!pfd_q && !cnt_clr) |=> $stable(loss_cnt))
    else $error("loss counted while phase detector off");

  // R8
  ref_lost_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_ok |=> (pll_rst_q && !ready_q))
    else $error("reference loss did not force reset");
endmodule

// File: tb/pll_supervisor_test.sv
module pll_supervisor_test;
  localparam int SS = 2, W = 16, N = 4, R = 8, L = 4, DLY = 5, REF_HALF = 3;

  logic clk = 1'b0, rst = 1'b1, ref_clk = 1'b0, lock = 1'b0;
  logic freeze = 1'b0, cnt_clr = 1'b0;
  logic pll_rst, pfd_en, ready;
  logic [7:0] loss_cnt;

  int n_cmp = 0, n_bad = 0;
  bit ref_run = 0, drop = 0, chatter = 0, cmp_en = 0;
  int ref_ph = 0, lk_cnt = 0;

  // model state
  int m_r1, m_r2, m_rd, m_win, m_seen, m_good, m_refok, m_l1, m_l2, m_pfd;
  int m_st, m_tmr, m_prst, m_rdy, m_cnt;

  pll_supervisor #(.SYNC_STAGES(SS), .WIN_CYCLES(W), .GOOD_WINDOWS(N),
                   .RST_CYCLES(R), .LOCK_CYCLES(L), .CNT_W(8)) uut (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .pll_lock_async(lock),
    .freeze(freeze), .cnt_clr(cnt_clr), .pll_rst(pll_rst), .pfd_en(pfd_en),
    .ready(ready), .loss_cnt(loss_cnt)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference clock source
  always @(negedge clk) if (ref_run) begin
    ref_ph++;
    if (ref_ph >= REF_HALF) begin ref_clk = ~ref_clk; ref_ph = 0; end
  end

  // behavioural PLL stub
  always @(negedge clk) begin
    if (pll_rst) begin lk_cnt = 0; lock = 1'b0; end
    else if (!pfd_en && chatter) lock = ~lock;
    else if (pfd_en) begin
      if (lk_cnt < DLY) lk_cnt++;
      lock = (lk_cnt >= DLY) && !drop;
    end
  end

  // cycle model
  always @(posedge clk) begin : mdl
    int e, nwin, nseen, ngood, nrefok, nst, ntmr, ncnt, evt;
    if (rst) begin
      m_r1 = 0; m_r2 = 0; m_rd = 0; m_win = 0; m_seen = 0; m_good = 0; m_refok = 0;
      m_l1 = 0; m_l2 = 0; m_pfd = 1; m_st = 0; m_tmr = 0; m_prst = 1; m_rdy = 0; m_cnt = 0;
    end else begin
      e = m_r2 ^ m_rd;
      if (m_win == W - 1) begin
        nwin = 0; nseen = 0;
        if (m_seen != 0 || e != 0) ngood = (m_good < N) ? m_good + 1 : N;
        else ngood = 0;
        nrefok = (ngood == N);
      end else begin
        nwin = m_win + 1; nseen = m_seen | e; ngood = m_good; nrefok = m_refok;
      end
      nst = m_st; ntmr = m_tmr; evt = 0;
      if (m_refok == 0) begin nst = 0; ntmr = 0; end
      else case (m_st)
        0: begin nst = 1; ntmr = 0; end
        1: if (m_tmr == R - 1) begin nst = 2; ntmr = 0; end else ntmr = m_tmr + 1;
        2: if (m_pfd != 0) begin
             if (m_l2 != 0) begin
               if (m_tmr == L - 1) begin nst = 3; ntmr = 0; end else ntmr = m_tmr + 1;
             end else ntmr = 0;
           end
        default: if (m_pfd != 0 && m_l2 == 0) begin evt = 1; nst = 1; ntmr = 0; end
      endcase
      if (cnt_clr) ncnt = 0;
      else if (evt != 0 && m_cnt < 255) ncnt = m_cnt + 1;
      else ncnt = m_cnt;
      m_rd = m_r2; m_r2 = m_r1; m_r1 = int'(ref_clk);
      m_l2 = m_l1; m_l1 = int'(lock); m_pfd = freeze ? 0 : 1;
      m_win = nwin; m_seen = nseen; m_good = ngood; m_refok = nrefok;
      m_st = nst; m_tmr = ntmr; m_cnt = ncnt;
      m_prst = (nst <= 1) ? 1 : 0; m_rdy = (nst == 3) ? 1 : 0;
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (cmp_en) begin
    chk("R3", "pll_rst", int'(pll_rst), m_prst);
    chk("R4", "ready", int'(ready), m_rdy);
    chk("R5", "loss_cnt", int'(loss_cnt), m_cnt);
    chk("R6", "pfd_en", int'(pfd_en), m_pfd);
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic wait_ready();
    int g = 0;
    while (!ready && g < 1000) begin @(negedge clk); g++; end
    chk("R4", "ready after lock", int'(ready), 1);
  endtask

  task automatic lose_lock(output int len);
    int g = 0;
    drop = 1;
    while (!pll_rst && g < 200) begin @(negedge clk); g++; end
    drop = 0;
    len = 0;
    while (pll_rst && len < 200) begin len++; @(negedge clk); end
  endtask

  initial begin
    int cyc, len;
    @(negedge clk); cmp_en = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "pll_rst in reset", int'(pll_rst), 1);
    chk("R1", "ready in reset", int'(ready), 0);
    chk("R1", "pfd_en in reset", int'(pfd_en), 1);
    chk("R1", "loss_cnt in reset", int'(loss_cnt), 0);
    rst = 0;

    // R2 no reference: reset held
    repeat (5 * W) @(negedge clk);
    chk("R2", "pll_rst without reference", int'(pll_rst), 1);
    ref_run = 1; cyc = 0;
    while (pll_rst && cyc < 1000) begin @(negedge clk); cyc++; end
    chk("R2", "release not before stable windows", int'(cyc >= (N - 1) * W + R), 1);

    wait_ready();
    chk("R4", "reset low while ready", int'(pll_rst), 0);

    // R5 / R3 loss of lock
    lose_lock(len);
    chk("R3", "reset pulse length", len, R);
    chk("R5", "loss count after first loss", int'(loss_cnt), 1);
    wait_ready();

    // R6 / R7 freeze
    freeze = 1;
    @(negedge clk);
    chk("R6", "pfd_en one cycle after freeze", int'(pfd_en), 0);
    chatter = 1; drop = 1;
    repeat (30) @(negedge clk);
    chk("R7", "no reset while frozen", int'(pll_rst), 0);
    chk("R7", "ready held while frozen", int'(ready), 1);
    chk("R7", "no count while frozen", int'(loss_cnt), 1);
    chatter = 0; drop = 0;
    repeat (4) @(negedge clk);
    freeze = 0;
    repeat (6) @(negedge clk);
    chk("R7", "still locked after unfreeze", int'(ready), 1);

    // R10 clear coinciding with loss event
    drop = 1;
    cyc = 0;
    while (!(m_st == 3 && m_pfd != 0 && m_l2 == 0 && m_refok != 0) && cyc < 200) begin
      @(negedge clk); cyc++;
    end
    cnt_clr = 1;
    @(negedge clk);
    cnt_clr = 0; drop = 0;
    chk("R10", "clear beats same-cycle loss", int'(loss_cnt), 0);
    chk("R5", "reset reissued on coinciding loss", int'(pll_rst), 1);
    wait_ready();

    // R9 saturation
    for (int k = 0; k < 260; k++) begin
      lose_lock(len);
      wait_ready();
    end
    chk("R9", "saturated count", int'(loss_cnt), 255);
    cnt_clr = 1;
    @(negedge clk);
    cnt_clr = 0;
    chk("R10", "plain clear", int'(loss_cnt), 0);

    // R8 reference stops
    ref_run = 0;
    repeat (3 * W) @(negedge clk);
    chk("R8", "reset forced on reference loss", int'(pll_rst), 1);
    chk("R8", "ready dropped on reference loss", int'(ready), 0);
    chk("R8", "reference loss not counted", int'(loss_cnt), 0);
    ref_run = 1;
    wait_ready();

    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule